// File: doc/BRIEF.md
# Codec GPIO Slot Controller

This block links a codec's general-purpose pins to the host through slot 12 of an AC'97-style serial link, and gathers everything into one 32-bit control/status word. On the transmit side it fills slot 12 with the host's pin values and marks the slot valid, or fills it with zeros and marks it invalid, depending on an enable bit. On the receive side it keeps the most recent slot 12 word that arrived with a valid tag.

Two sticky interrupt flags are kept. The first records a GPIO event, which is a valid received slot whose lowest bit is 1. The second records a wakeup, which is a rising edge on either serial data input line while the codec is powered down. Each flag is armed only by its own enable bit. Reading the register clears both flags, and the interrupt line is the OR of the two flags. Frame assembly and power sequencing are handled outside this block. The frame logic uses the slot strobe and tag ports, and the power state comes in on a single input.

Top module: `cgpio_slot_ctrl`

## Requirements
- R1: After reset, the register reads 00000000h, `irq` is 0, and `tx_slot_tag` and `tx_slot_data` are 0.
- R2: Bit 31 enables transmission. While it is 1, `tx_slot_data` carries `host_pins` and `tx_slot_tag` is 1. While it is 0, both are 0. The outputs follow the stored bit one clock later.
- R3: A pulse on `rx_slot_stb` with `rx_slot_tag`=1 and `rx_slot_data[0]`=1 sets the GPIO flag (bit 21) only when bit 30 is 1.
- R4: While `codec_pd`=1 and bit 29 is 1, a 0-to-1 change on either bit of `sdin_lines` sets the wakeup flag (bit 20). This takes effect after the two-flop synchronizer. A line that is already high when power-down begins does not count as an edge, and no edge sets the flag while `codec_pd`=0.
- R5: Writing 1 to bit 29 while `codec_pd`=0 leaves the bit unchanged. While `codec_pd`=1 the write takes effect. Writing 0 always takes effect.
- R6: A pulse on `reg_rd` loads `reg_rdata` on the next edge with {bit31, bit30, bit29, 7 zeros, GPIO flag, wake flag, status[19:0]}. Both flags then clear. Bits 28:22 always read 0.
- R7: Status bits 19:0 take all 20 bits of `rx_slot_data` whenever `rx_slot_stb` and `rx_slot_tag` are both 1. Otherwise they hold.
- R8: If a flag-setting event falls in the same cycle as a read, the flag stays set afterwards. The data returned by that read shows the value from before the event.
- R9: `irq` is 1 exactly when at least one flag is set, and it falls only after a read.
- R10: Writes change only bits 31:29. The flag bits and status bits ignore write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (clears flags) |
| reg_rdata | output | 32 | Registered read data |
| host_pins | input | 20 | Pin values to send in slot 12 |
| tx_slot_data | output | 20 | Outgoing slot 12 payload |
| tx_slot_tag | output | 1 | Outgoing slot 12 valid tag |
| rx_slot_stb | input | 1 | Received slot 12 is present this cycle |
| rx_slot_tag | input | 1 | Valid tag of the received slot 12 |
| rx_slot_data | input | 20 | Received slot 12 payload |
| codec_pd | input | 1 | Codec is powered down |
| sdin_lines | input | 2 | Serial data input lines watched for wakeup |
| irq | output | 1 | Interrupt request |

## Verification
The assertions run on every cycle. They check that the transmit payload is zero whenever its tag is low, that the status holds between valid slots, and that a flag rises only when its enable is set. They also check that a set flag survives every cycle without a read, that the wake-enable lock holds while powered up, that no wake event appears while powered up, and that `irq` falls only after a read. Some behaviour can only be shown by the bench's scenarios. This includes the exact values returned by each read and the race between a read and an event. It also includes the absence of a false edge when power-down begins with a line already high, and the latency from a line change to the flag.

// File: rtl/cgpio_pkg.sv
package cgpio_pkg;
  localparam int REG_W      = 32;
  localparam int SLOT_W     = 20;
  localparam int BIT_TX_EN  = 31;
  localparam int BIT_INT_EN = 30;
  localparam int BIT_WK_EN  = 29;
  localparam int BIT_INT_FL = 21;
  localparam int BIT_WK_FL  = 20;
  localparam int RSVD_HI    = 28;
  localparam int RSVD_LO    = 22;

  typedef struct packed {
    logic tx_en;
    logic int_en;
    logic wk_en;
  } ctrl_t;
endpackage

// File: rtl/cgpio_slot_tx.sv
module cgpio_slot_tx #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] pins,
  output logic [W-1:0] data_o,
  output logic         tag_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      tag_o  <= 1'b0;
    end else begin
      tag_o  <= en;
      data_o <= en ? pins : '0;
    end
  end

  // R2: an invalid slot never carries data
  p_tx_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !tag_o |-> (data_o == '0));
endmodule

// File: rtl/cgpio_slot_rx.sv
module cgpio_slot_rx #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  input  logic         tag,
  input  logic [W-1:0] data,
  output logic [W-1:0] status,
  output logic         evt
);
  logic take;
  assign take = stb & tag;
  assign evt  = take & data[0];

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else if (take) status <= data;
  end

  // R7: status only moves on a valid slot
  p_status_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(status));
endmodule

// File: rtl/cgpio_wake_det.sv
module cgpio_wake_det #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd,
  input  logic [LANES-1:0] lines,
  output logic             evt
);
  localparam int CHAIN_W = LANES * STAGES;

  logic [CHAIN_W-1:0] chain;
  logic [LANES-1:0]   synced, prev, rise;
  logic               armed;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= lines;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-LANES-1:0], lines};
      end
    end
  endgenerate

  assign synced = chain[CHAIN_W-1 -: LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '0;
      armed <= 1'b0;
    end else begin
      prev  <= synced;
      armed <= pd;
    end
  end

  assign rise = synced & ~prev;
  assign evt  = armed & pd & (|rise);

  // R4: no wake event is produced while the codec is powered up
  p_no_wake_up_r4: assert property (@(posedge clk) disable iff (rst)
    !pd |=> !evt);
endmodule

// File: rtl/cgpio_slot_ctrl.sv
module cgpio_slot_ctrl
  import cgpio_pkg::*;
#(
  parameter int LANES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [SLOT_W-1:0] host_pins,
  output logic [SLOT_W-1:0] tx_slot_data,
  output logic              tx_slot_tag,
  input  logic              rx_slot_stb,
  input  logic              rx_slot_tag,
  input  logic [SLOT_W-1:0] rx_slot_data,
  input  logic              codec_pd,
  input  logic [LANES-1:0]  sdin_lines,
  output logic              irq
);
  localparam int RSVD_W = RSVD_HI - RSVD_LO + 1;

  ctrl_t             ctrl;
  logic              fl_int, fl_wk, fl_int_n, fl_wk_n;
  logic              gpio_evt, wake_evt;
  logic [SLOT_W-1:0] status;
  logic [REG_W-1:0]  view;

  cgpio_slot_tx #(.W(SLOT_W)) u_tx (
    .clk(clk), .rst(rst), .en(ctrl.tx_en), .pins(host_pins),
    .data_o(tx_slot_data), .tag_o(tx_slot_tag));

  cgpio_slot_rx #(.W(SLOT_W)) u_rx (
    .clk(clk), .rst(rst), .stb(rx_slot_stb), .tag(rx_slot_tag),
    .data(rx_slot_data), .status(status), .evt(gpio_evt));

  cgpio_wake_det #(.LANES(LANES), .STAGES(SYNC_STAGES)) u_wk (
    .clk(clk), .rst(rst), .pd(codec_pd), .lines(sdin_lines), .evt(wake_evt));

  assign view = {ctrl.tx_en, ctrl.int_en, ctrl.wk_en, {RSVD_W{1'b0}},
                 fl_int, fl_wk, status};

  // a same-cycle event wins over the read's clear
  assign fl_int_n = (fl_int & ~reg_rd) | (gpio_evt & ctrl.int_en);
  assign fl_wk_n  = (fl_wk  & ~reg_rd) | (wake_evt & ctrl.wk_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      fl_int    <= 1'b0;
      fl_wk     <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        ctrl.tx_en  <= reg_wdata[BIT_TX_EN];
        ctrl.int_en <= reg_wdata[BIT_INT_EN];
        // setting the wake enable is honoured only while powered down
        if (!reg_wdata[BIT_WK_EN])
          ctrl.wk_en <= 1'b0;
        else if (codec_pd)
          ctrl.wk_en <= 1'b1;
      end
      fl_int <= fl_int_n;
      fl_wk  <= fl_wk_n;
      irq    <= fl_int_n | fl_wk_n;
      if (reg_rd) reg_rdata <= view;
    end
  end

  // R5: a set attempt while powered up leaves the enable clear
  p_wk_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[BIT_WK_EN] && !codec_pd && !ctrl.wk_en) |=> !ctrl.wk_en);
  // R3: GPIO flag rises only with its enable set
  p_int_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_int) |-> $past(ctrl.int_en));
  // R4: wake flag rises only with its enable set
  p_wk_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_wk) |-> $past(ctrl.wk_en));
  // R8: flags persist until read
  p_int_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (fl_int && !reg_rd) |=> fl_int);
  p_wk_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (fl_wk && !reg_rd) |=> fl_wk);
  // R9: interrupt drops only as the result of a read
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(reg_rd));
  // R6: reserved field of the returned word is zero
  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[RSVD_HI:RSVD_LO] == '0);
endmodule

// File: tb/sim_cgpio_slot_ctrl.sv
`timescale 1ns/1ps
module sim_cgpio_slot_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [19:0] host_pins = '0, tx_slot_data, rx_slot_data = '0;
  logic        tx_slot_tag, rx_slot_stb = 1'b0, rx_slot_tag = 1'b0;
  logic        codec_pd = 1'b0, irq;
  logic [1:0]  sdin_lines = '0;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] r;
  logic [19:0] exp_st;

  always #10 clk = ~clk;

  cgpio_slot_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .host_pins(host_pins),
    .tx_slot_data(tx_slot_data), .tx_slot_tag(tx_slot_tag),
    .rx_slot_stb(rx_slot_stb), .rx_slot_tag(rx_slot_tag),
    .rx_slot_data(rx_slot_data), .codec_pd(codec_pd),
    .sdin_lines(sdin_lines), .irq(irq));

  // {int_en, tag, data[19:0], expected status[19:0], expected GPIO flag}
  localparam int NV = 6;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 1'b1, 20'h12345, 20'h12345, 1'b1},
    {1'b1, 1'b0, 20'hFFFFF, 20'h12345, 1'b0},
    {1'b0, 1'b1, 20'hABCDF, 20'hABCDF, 1'b0},
    {1'b1, 1'b1, 20'h80000, 20'h80000, 1'b0},
    {1'b1, 1'b1, 20'hFFFFF, 20'hFFFFF, 1'b1},
    {1'b0, 1'b0, 20'h00001, 20'hFFFFF, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic slot(input logic t, input logic [19:0] d);
    @(negedge clk); rx_slot_stb = 1'b1; rx_slot_tag = t; rx_slot_data = d;
    @(negedge clk); rx_slot_stb = 1'b0; rx_slot_tag = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    // R1: reset state
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 tx", {11'b0, tx_slot_tag, tx_slot_data}, 32'h0);
    rd(r);
    check("R1 read", r, 32'h0);

    // R2: transmit enable
    host_pins = 20'h5A5A5;
    wr(32'h8000_0000);
    wait_cyc(1);
    check("R2 enabled", {11'b0, tx_slot_tag, tx_slot_data}, {11'b0, 1'b1, 20'h5A5A5});
    wr(32'h0);
    wait_cyc(1);
    check("R2 disabled", {11'b0, tx_slot_tag, tx_slot_data}, 32'h0);

    // R3 / R7: vector table
    for (int i = 0; i < NV; i++) begin
      wr({1'b0, VEC[i][42], 30'b0});
      slot(VEC[i][41], VEC[i][40:21]);
      rd(r);
      check("R7 status", {12'b0, r[19:0]}, {12'b0, VEC[i][20:1]});
      check("R3 gpio flag", {31'b0, r[21]}, {31'b0, VEC[i][0]});
    end
    exp_st = 20'hFFFFF;

    // R10: only 31:29 writable (R5: bit 29 blocked while powered up)
    wr(32'hFFFF_FFFF);
    rd(r);
    check("R10 write mask", r, {12'hC00, exp_st});
    wr(32'h0);

    // R5: setting wake enable while powered down
    codec_pd = 1'b1;
    wait_cyc(3);
    wr(32'h2000_0000);
    rd(r);
    check("R5 set while down", r, {12'h200, exp_st});

    // R4 / R9: rising edge on lane 1
    sdin_lines = 2'b10;
    wait_cyc(6);
    check("R9 irq on wake", {31'b0, irq}, 32'h1);
    rd(r);
    check("R4 lane1 flag", {31'b0, r[20]}, 32'h1);
    check("R9 irq after read", {31'b0, irq}, 32'h0);
    sdin_lines = 2'b11;
    wait_cyc(6);
    rd(r);
    check("R4 lane0 flag", {31'b0, r[20]}, 32'h1);
    rd(r);
    check("R6 flag cleared", {31'b0, r[20]}, 32'h0);

    // R4: no effect while powered up
    sdin_lines = 2'b00;
    wait_cyc(4);
    codec_pd = 1'b0;
    wait_cyc(3);
    sdin_lines = 2'b01;
    wait_cyc(6);
    rd(r);
    check("R4 ignored when up", {31'b0, r[20]}, 32'h0);
    // R4: line already high at power-down is not an edge
    codec_pd = 1'b1;
    wait_cyc(6);
    rd(r);
    check("R4 no false edge", {31'b0, r[20]}, 32'h0);
    // R4: enable cleared -> edge ignored
    wr(32'h0);
    sdin_lines = 2'b00;
    wait_cyc(4);
    sdin_lines = 2'b01;
    wait_cyc(6);
    rd(r);
    check("R4 disabled", {31'b0, r[20]}, 32'h0);
    check("R9 irq idle", {31'b0, irq}, 32'h0);

    // R5: blocked while powered up
    codec_pd = 1'b0;
    wait_cyc(2);
    wr(32'h2000_0000);
    rd(r);
    check("R5 blocked while up", {31'b0, r[29]}, 32'h0);

    // R8: event and read in the same cycle
    wr(32'h4000_0000);
    @(negedge clk);
    reg_rd = 1'b1; rx_slot_stb = 1'b1; rx_slot_tag = 1'b1; rx_slot_data = 20'h00003;
    @(negedge clk);
    reg_rd = 1'b0; rx_slot_stb = 1'b0; rx_slot_tag = 1'b0;
    r = reg_rdata;
    check("R8 read shows old", r, {12'h400, exp_st});
    check("R9 irq kept", {31'b0, irq}, 32'h1);
    rd(r);
    check("R8 flag kept", r, {12'h402, 20'h00003});
    check("R6 irq cleared", {31'b0, irq}, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule